// File: doc/BRIEF.md
# Receive Elastic Buffer

This block sits between a receive port and a forwarding transmit path on a nibble-wide media-independent stream. Each nibble that arrives with its data-valid flag set is stored with a tag that says whether it closes its packet. The transmit side holds a packet back by raising `tx_hold`. While the hold is high, whole packets queue up in the buffer, so the transmitter can absorb the arrival jitter. When the hold drops, each packet is sent out as one unbroken run of `out_dv`. A fixed number of idle cycles is always placed between two forwarded packets.

Several closely spaced packets can wait in the buffer together, and each keeps its own boundary. A packet made of a single nibble, with no payload, goes through as a one-cycle pulse and does not disturb the packets around it. If a nibble must be stored while the buffer is already full, the buffer discards everything it holds. It also drops the rest of the packet that was arriving, raises a sticky overflow flag, and then accepts the next packet normally. A fault input overrides the hold, so a wedged transmitter cannot fill the buffer during fault recovery. This override lasts while the fault is high and until the buffer has drained.

Top module: `rx_elastic_buf`

## Requirements
- R1: After reset, `out_dv` and `ovf_flag` are 0.
- R2: A packet is forwarded with its nibbles unchanged and in order, with `out_dv` high for exactly its length. With `tx_hold` low, `out_dv` rises on the second clock edge after the edge that samples the first nibble. With `tx_hold` high, no packet starts, and a packet held for 32 or more cycles still comes out intact once the hold drops.
- R3: `tx_hold` only gates the start of a packet. A packet already being forwarded runs to its end even if `tx_hold` rises during it.
- R4: Several packets separated by a single idle input cycle are all stored while held. They come out in order with their boundaries kept, and `out_dv` stays low for at least MIN_GAP cycles (default 2) between packets.
- R5: A packet of one nibble is forwarded as a single-cycle `out_dv` pulse, and the packets before and after it are unaffected.
- R6: A nibble that arrives for storage while DEPTH entries (default 64) are held causes an overflow. All stored entries are discarded, `out_dv` is 0 on the next cycle, and the remaining nibbles of the arriving packet are dropped. The next packet is accepted and forwarded intact. No more than DEPTH entries are ever stored.
- R7: `ovf_flag` is set by an overflow and stays set until a cycle in which `ovf_clr` is high. It reads 0 after that cycle, except when an overflow occurs in the same cycle; in that case setting wins.
- R8: From the cycle after `fault` is sampled high, `tx_hold` is ignored until `fault` is low and the buffer is empty. Stored data therefore starts leaving within 8 cycles of a fault, still with the MIN_GAP spacing. After the fault ends and the buffer drains, `tx_hold` takes effect again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_dv | input | 1 | Receive data valid; one run of high cycles is one packet |
| rx_nib | input | 4 | Receive nibble |
| tx_hold | input | 1 | Transmit side asks that no new packet start |
| fault | input | 1 | Fault indication; forces the hold to release |
| ovf_clr | input | 1 | Host write pulse that clears the overflow flag |
| out_dv | output | 1 | Forwarded data valid |
| out_nib | output | 4 | Forwarded nibble |
| ovf_flag | output | 1 | Sticky overflow status |

## Verification
The hardest case to reach from the ports is an overflow that strikes while earlier complete packets are still stored and the arriving packet is only part way in. That overflow must flush the old packets, discard the tail of the new one, and leave the buffer ready for the next packet. The bench gets there by holding the transmitter off, queuing a short packet, and then sending a packet longer than the remaining space. It then checks that nothing leaves after the hold drops, and that a fresh packet still passes unchanged. The fault override is reached the same way: data is left stored under a hold, and `fault` is raised without ever dropping the hold.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;

    localparam int unsigned NIB_W = 4;

    // One stored entry: the nibble plus a flag marking the last nibble of a packet
    typedef struct packed {
        logic             last;
        logic [NIB_W-1:0] nib;
    } ent_t;

endpackage

// File: rtl/ebuf_wr_tag.sv
// Input staging: delays each nibble by one cycle so that the end-of-packet
// tag can be attached once rx_dv is seen falling; drops packet tails after overflow.
module ebuf_wr_tag
    import ebuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_dv,
    input  logic [NIB_W-1:0] rx_nib,
    input  logic             full,
    output logic             push,
    output logic             ovf_evt,
    output ent_t             wr_ent
);

    typedef struct packed {
        logic             vld;
        logic             drop;
        logic [NIB_W-1:0] nib;
    } stage_t;

    stage_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        push        = s_q.vld && !full;
        ovf_evt     = s_q.vld && full;
        wr_ent.last = !rx_dv;
        wr_ent.nib  = s_q.nib;

        if (ovf_evt) begin
            s_d.vld  = 1'b0;
            s_d.drop = rx_dv;
        end else begin
            s_d.drop = s_q.drop && rx_dv;
            s_d.vld  = rx_dv && !s_q.drop;
            if (rx_dv) begin
                s_d.nib = rx_nib;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ebuf_store.sv
// Circular entry storage with pointers and an occupancy count; flush empties it.
module ebuf_store
    import ebuf_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  ent_t             wr_ent,
    output ent_t             rd_ent,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t p_d, p_q;
    ent_t mem [DEPTH];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    always_comb begin
        p_d = p_q;
        if (flush) begin
            p_d = '0;
        end else begin
            if (push) begin
                p_d.wr = ptr_inc(p_q.wr);
            end
            if (pop) begin
                p_d.rd = ptr_inc(p_q.rd);
            end
            if (push && !pop) begin
                p_d.cnt = p_q.cnt + 1'b1;
            end else if (pop && !push) begin
                p_d.cnt = p_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[p_q.wr] <= wr_ent;
        end
    end

    assign rd_ent = mem[p_q.rd];
    assign count  = p_q.cnt;
    assign empty  = (p_q.cnt == '0);
    assign full   = (p_q.cnt == CNT_W'(DEPTH));

endmodule

// File: rtl/ebuf_rd_ctrl.sv
// Output side: starts packets only when not held, finishes started packets,
// inserts the inter-packet gap and latches the fault release.
module ebuf_rd_ctrl
    import ebuf_pkg::*;
#(
    parameter int unsigned MIN_GAP = 2,
    localparam int unsigned GAP_W = $clog2(MIN_GAP + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_hold,
    input  logic             fault,
    input  logic             flush,
    input  logic             empty,
    input  ent_t             rd_ent,
    output logic             pop,
    output logic             out_dv,
    output logic [NIB_W-1:0] out_nib,
    output logic             out_last,
    output logic             rel
);

    typedef struct packed {
        logic             dv;
        logic             last;
        logic [NIB_W-1:0] nib;
        logic             in_pkt;
        logic             rel;
        logic [GAP_W-1:0] gap;
    } rd_t;

    rd_t r_d, r_q;
    logic hold_eff;

    always_comb begin
        r_d      = r_q;
        hold_eff = tx_hold && !r_q.rel;
        pop      = !flush && !empty && (r_q.gap == '0) && (r_q.in_pkt || !hold_eff);

        r_d.rel  = fault || (r_q.rel && (!empty || r_q.in_pkt));

        if (flush) begin
            r_d.dv     = 1'b0;
            r_d.last   = 1'b0;
            r_d.in_pkt = 1'b0;
            r_d.gap    = '0;
        end else if (pop) begin
            r_d.dv     = 1'b1;
            r_d.nib    = rd_ent.nib;
            r_d.last   = rd_ent.last;
            r_d.in_pkt = !rd_ent.last;
            r_d.gap    = rd_ent.last ? GAP_W'(MIN_GAP) : '0;
        end else begin
            r_d.dv   = 1'b0;
            r_d.last = 1'b0;
            if (r_q.gap != '0) begin
                r_d.gap = r_q.gap - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_dv   = r_q.dv;
    assign out_nib  = r_q.nib;
    assign out_last = r_q.last;
    assign rel      = r_q.rel;

endmodule

// File: rtl/rx_elastic_buf.sv
// Receive elastic buffer top: write tagging, storage, read control, overflow flag.
module rx_elastic_buf
    import ebuf_pkg::*;
#(
    parameter int unsigned DEPTH   = 64,
    parameter int unsigned MIN_GAP = 2,
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_dv,
    input  logic [NIB_W-1:0] rx_nib,
    input  logic             tx_hold,
    input  logic             fault,
    input  logic             ovf_clr,
    output logic             out_dv,
    output logic [NIB_W-1:0] out_nib,
    output logic             ovf_flag
);

    typedef struct packed {
        logic flag;
    } stat_t;

    stat_t f_d, f_q;

    logic             push;
    logic             pop;
    logic             ovf_evt;
    logic             full;
    logic             empty;
    logic             out_last;
    logic             rel;
    logic [CNT_W-1:0] count;
    ent_t             wr_ent;
    ent_t             rd_ent;

    ebuf_wr_tag i_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_dv   (rx_dv),
        .rx_nib  (rx_nib),
        .full    (full),
        .push    (push),
        .ovf_evt (ovf_evt),
        .wr_ent  (wr_ent)
    );

    ebuf_store #(.DEPTH(DEPTH)) i_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .pop    (pop),
        .flush  (ovf_evt),
        .wr_ent (wr_ent),
        .rd_ent (rd_ent),
        .count  (count),
        .empty  (empty),
        .full   (full)
    );

    ebuf_rd_ctrl #(.MIN_GAP(MIN_GAP)) i_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_hold  (tx_hold),
        .fault    (fault),
        .flush    (ovf_evt),
        .empty    (empty),
        .rd_ent   (rd_ent),
        .pop      (pop),
        .out_dv   (out_dv),
        .out_nib  (out_nib),
        .out_last (out_last),
        .rel      (rel)
    );

    always_comb begin
        f_d = f_q;
        if (ovf_evt) begin
            f_d.flag = 1'b1;
        end else if (ovf_clr) begin
            f_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign ovf_flag = f_q.flag;

endmodule

// File: rtl/rx_elastic_buf_chk.sv
module rx_elastic_buf_chk #(
    parameter int unsigned DEPTH   = 64,
    parameter int unsigned MIN_GAP = 2,
    parameter int unsigned CNT_W   = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_dv,
    input logic             out_last,
    input logic             ovf_flag,
    input logic             ovf_clr,
    input logic             ovf_evt,
    input logic [CNT_W-1:0] count,
    input logic             fault,
    input logic             tx_hold,
    input logic             rel
);

    logic [3:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (fault && (count != '0) && !out_dv) begin
            wait_cnt <= (wait_cnt == 4'hf) ? wait_cnt : wait_cnt + 1'b1;
        end else begin
            wait_cnt <= '0;
        end
    end

    AST_HOLD_GATES_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_dv) |-> $past(!tx_hold || rel)); // R2

    AST_PKT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_dv && out_last && MIN_GAP >= 2) |=> !out_dv ##1 !out_dv); // R4

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (count == '0) && !out_dv); // R6

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R6

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag); // R7

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !ovf_evt) |=> !ovf_flag); // R7

    AST_FAULT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= 4'd8); // R8

endmodule

bind rx_elastic_buf rx_elastic_buf_chk #(
    .DEPTH   (DEPTH),
    .MIN_GAP (MIN_GAP),
    .CNT_W   (CNT_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_dv   (out_dv),
    .out_last (out_last),
    .ovf_flag (ovf_flag),
    .ovf_clr  (ovf_clr),
    .ovf_evt  (ovf_evt),
    .count    (count),
    .fault    (fault),
    .tx_hold  (tx_hold),
    .rel      (rel)
);

// File: tb/test_rx_elastic_buf.sv
`timescale 1ns/1ps
module test_rx_elastic_buf;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_dv = 1'b0;
    logic [3:0] rx_nib = '0;
    logic       tx_hold = 1'b0;
    logic       fault = 1'b0;
    logic       ovf_clr = 1'b0;
    logic       out_dv;
    logic [3:0] out_nib;
    logic       ovf_flag;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    int obs_nib[$];
    bit obs_start[$];
    int exp_nib[$];
    bit exp_start[$];
    int gap_err = 0;
    int low_run = 100;
    bit prev_dv = 0;
    int rise_cyc = -1;
    int first_cyc = 0;

    rx_elastic_buf i_rx_elastic_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_dv    (rx_dv),
        .rx_nib   (rx_nib),
        .tx_hold  (tx_hold),
        .fault    (fault),
        .ovf_clr  (ovf_clr),
        .out_dv   (out_dv),
        .out_nib  (out_nib),
        .ovf_flag (ovf_flag)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Output monitor, sampled between edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_dv) begin
                if (!prev_dv) begin
                    if (low_run < 2) gap_err++;
                    rise_cyc = cyc;
                end
                obs_nib.push_back(int'(out_nib));
                obs_start.push_back(!prev_dv);
                low_run = 0;
            end else begin
                low_run++;
            end
            prev_dv = out_dv;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_pkt(input int len, input int seed, input bit keep);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_dv  = 1'b1;
            rx_nib = 4'((seed + i * 3) & 15);
            if (i == 0) first_cyc = cyc + 1;
            if (keep) begin
                exp_nib.push_back((seed + i * 3) & 15);
                exp_start.push_back(i == 0);
            end
        end
        @(negedge clk);
        rx_dv = 1'b0;
    endtask

    task automatic cmp_stream(input string req);
        int mism = -1;
        chk(obs_nib.size() == exp_nib.size(), req, "stream length",
            obs_nib.size(), exp_nib.size());
        for (int i = 0; i < obs_nib.size() && i < exp_nib.size(); i++) begin
            if (mism < 0 && (obs_nib[i] != exp_nib[i] || obs_start[i] != exp_start[i]))
                mism = i;
        end
        chk(mism < 0, req, "first mismatching nibble index", mism, -1);
        obs_nib.delete(); obs_start.delete();
        exp_nib.delete(); exp_start.delete();
    endtask

    function automatic int count_starts();
        int n = 0;
        foreach (obs_start[i]) if (obs_start[i]) n++;
        return n;
    endfunction

    task automatic t_reset();
        chk(out_dv == 1'b0, "R1", "out_dv after reset", out_dv, 0);
        chk(ovf_flag == 1'b0, "R1", "ovf_flag after reset", ovf_flag, 0);
    endtask

    task automatic t_latency();
        tx_hold = 1'b0;
        send_pkt(5, 1, 1);
        idle(10);
        chk(rise_cyc == first_cyc + 2, "R2", "cycle of out_dv rise", rise_cyc, first_cyc + 2);
        cmp_stream("R2");
    endtask

    task automatic t_held();
        tx_hold = 1'b1;
        send_pkt(20, 7, 1);
        idle(40);
        chk(obs_nib.size() == 0, "R2", "nibbles out under hold", obs_nib.size(), 0);
        tx_hold = 1'b0;
        idle(30);
        cmp_stream("R2");
    endtask

    task automatic t_multi();
        int pk;
        gap_err = 0;
        tx_hold = 1'b1;
        send_pkt(6, 2, 1);
        send_pkt(1, 9, 1);
        send_pkt(9, 4, 1);
        idle(5);
        tx_hold = 1'b0;
        idle(40);
        pk = count_starts();
        chk(pk == 3, "R5", "packets seen incl. single-nibble one", pk, 3);
        chk(gap_err == 0, "R4", "short inter-packet gaps", gap_err, 0);
        cmp_stream("R4");
    endtask

    task automatic t_midhold();
        tx_hold = 1'b0;
        send_pkt(12, 5, 1);
        while (!out_dv) @(negedge clk);
        tx_hold = 1'b1;
        idle(30);
        cmp_stream("R3");
        send_pkt(4, 11, 1);
        idle(20);
        chk(obs_nib.size() == 0, "R3", "new packet started under hold", obs_nib.size(), 0);
        tx_hold = 1'b0;
        idle(20);
        cmp_stream("R3");
    endtask

    task automatic t_overflow();
        tx_hold = 1'b1;
        send_pkt(10, 3, 0);
        send_pkt(70, 8, 0);
        idle(3);
        chk(ovf_flag == 1'b1, "R7", "flag after overflow", ovf_flag, 1);
        idle(10);
        chk(ovf_flag == 1'b1, "R7", "flag held (sticky)", ovf_flag, 1);
        tx_hold = 1'b0;
        idle(30);
        chk(obs_nib.size() == 0, "R6", "nibbles out after flush", obs_nib.size(), 0);
        send_pkt(7, 13, 1);
        idle(20);
        cmp_stream("R6");
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        chk(ovf_flag == 1'b0, "R7", "flag after clear", ovf_flag, 0);
    endtask

    task automatic t_fault();
        int n = 0;
        gap_err = 0;
        tx_hold = 1'b1;
        send_pkt(8, 6, 1);
        idle(5);
        chk(obs_nib.size() == 0, "R8", "held before fault", obs_nib.size(), 0);
        fault = 1'b1;
        while (!out_dv && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(n <= 8, "R8", "cycles from fault to out_dv", n, 8);
        send_pkt(3, 10, 1);
        send_pkt(5, 12, 1);
        idle(30);
        chk(gap_err == 0, "R8", "gaps during fault release", gap_err, 0);
        cmp_stream("R8");
        fault = 1'b0;
        idle(5);
        send_pkt(4, 14, 1);
        idle(20);
        chk(obs_nib.size() == 0, "R8", "hold honoured after fault", obs_nib.size(), 0);
        tx_hold = 1'b0;
        idle(20);
        cmp_stream("R8");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_held();
        t_multi();
        t_midhold();
        t_overflow();
        t_fault();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc > 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule